// File: doc/BRIEF.md
# Hashed translation table probe

This block settles a translation miss with a single probe of a direct-mapped translation table held in memory. The table has a power-of-two number of 16-byte slots. Each slot pairs a stored tag with a page table entry. Given the faulting virtual address, the table's base address and a page-size select, the block does four things in turn:

- It works out which slot the address maps to.
- It issues one 128-bit read that returns the tag and the entry together.
- It compares the stored tag against a tag built from the upper address bits.
- It reports either a hit with the entry or a miss.

The caller starts a probe with a one-cycle `start` while `busy` is low. It then waits for `done`. When `hit` is high in the cycle of `done`, `entry` holds the translation. The table may mark a slot as locked while software updates it. An all-zero tag marks an empty slot. Neither kind of slot can produce a hit. Filling the table and any further walk after a miss belong to other blocks.

Top module: `hashed_xlat_probe`

## Requirements
- R1: After reset, `busy`, `done`, `hit` and `mem_req` are all low.
- R2: A `start` seen while `busy` is low raises `busy` and `mem_req` in the next cycle. A `start` seen while `busy` is high is ignored and leaves `mem_addr` unchanged.
- R3: When `big_page` is 0, `mem_addr` = base + ((( va >> 13) & 2047) << 4). This is 8 KiB pages and a table of 2048 slots.
- R4: When `big_page` is 1, `mem_addr` = base + (((va >> 22) & 4095) << 4). This is a table of 4096 slots.
- R5: `mem_req` and `mem_addr` hold steady until the cycle in which `mem_ack` is sampled high.
- R6: The response carries the tag in `mem_rdata[63:0]` and the entry in `mem_rdata[127:64]`. The compare tag has va[63:22] in bits 41:0 and zeros in every other bit. On a hit, `entry` equals the entry half of the response.
- R7: A stored tag with bit 47 set, the lock bit, always gives a miss, even if all its other bits match.
- R8: A stored tag of all zeros always gives a miss. This holds even when va[63:22] is zero.
- R9: A miss is reported for any stored tag with a nonzero context field (bits 60:48) or any other mismatching bit.
- R10: `done` is a one-cycle pulse in the cycle after `mem_ack` is sampled. `busy` and `mem_req` are low in that same cycle. `hit` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| va | input | 64 | Faulting virtual address |
| base | input | 64 | Table base address |
| big_page | input | 1 | 0: small-page table, 1: large-page table |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Tag matched (valid with done) |
| entry | output | 64 | Page table entry read from the slot |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 64 | Slot address of the read |
| mem_ack | input | 1 | Read data valid / request accepted |
| mem_rdata | input | 128 | Tag (low half) and entry (high half) |

## Verification
A wrong slot index or a wrong base addition shows up on `mem_addr` in the cycle right after `start`. The bench sweeps many addresses through both table sizes to catch it there. A corrupted compare tag, or a lost lock or zero-tag qualifier, shows up only as a wrong `hit` in the `done` cycle. For that reason each probe supplies a matching tag, a locked tag, a context-tagged tag and a one-bit mismatch. A state machine that drops or repeats its request shows up as a `mem_addr` that changes under a pending `mem_req`, or as a `done` that arrives early or twice.

// File: rtl/hashed_xlat_probe.sv
module hashed_xlat_probe #(
  parameter int PAGE_SHIFT    = 13,
  parameter int SMALL_ENTRIES = 2048,
  parameter int LARGE_ENTRIES = 4096,
  parameter int TAG_SHIFT     = 22,
  parameter int LOCK_BIT      = 47
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [63:0]  va,
  input  logic [63:0]  base,
  input  logic         big_page,
  output logic         busy,
  output logic         done,
  output logic         hit,
  output logic [63:0]  entry,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  input  logic         mem_ack,
  input  logic [127:0] mem_rdata
);
  localparam int SMALL_IDX_W = $clog2(SMALL_ENTRIES);
  localparam int LARGE_IDX_W = $clog2(LARGE_ENTRIES);
  localparam int SLOT_SHIFT  = 4;

  logic        waiting;
  logic [63:0] cmp_tag;
  logic [63:0] tag_in;
  logic [63:0] small_idx;
  logic [63:0] large_idx;
  logic [63:0] slot_addr;
  logic [63:0] stored;
  logic        match;
  logic        unused_va;

  assign tag_in    = {{TAG_SHIFT{1'b0}}, va[63:TAG_SHIFT]};
  assign small_idx = 64'(va[PAGE_SHIFT +: SMALL_IDX_W]);
  assign large_idx = 64'(tag_in[LARGE_IDX_W-1:0]);
  assign slot_addr = base + ((big_page ? large_idx : small_idx) << SLOT_SHIFT);
  assign unused_va = ^va[PAGE_SHIFT-1:0];

  assign stored = mem_rdata[63:0];
  assign match  = (stored == cmp_tag) && !stored[LOCK_BIT] && (|stored);

  assign busy    = waiting;
  assign mem_req = waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      done     <= 1'b0;
      hit      <= 1'b0;
      entry    <= '0;
      cmp_tag  <= '0;
      mem_addr <= '0;
    end else begin
      done <= 1'b0;
      hit  <= 1'b0;
      if (!waiting && start) begin
        waiting  <= 1'b1;
        cmp_tag  <= tag_in;
        mem_addr <= slot_addr;
      end else if (waiting && mem_ack) begin
        waiting <= 1'b0;
        done    <= 1'b1;
        hit     <= match;
        entry   <= mem_rdata[127:64];
      end
    end
  end
endmodule

module hashed_xlat_probe_chk #(
  parameter int LOCK_BIT = 47
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        hit,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic [63:0] tag_word
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_req && busy));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_lock_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !$past(tag_word[LOCK_BIT]));
  p_zero_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(tag_word) != 64'd0));
  p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));
  p_hit_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done);
endmodule

bind hashed_xlat_probe hashed_xlat_probe_chk #(.LOCK_BIT(LOCK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hit(hit), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .tag_word(mem_rdata[63:0])
);

// File: tb/hashed_xlat_probe_tb.sv
module hashed_xlat_probe_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  va = '0;
  logic [63:0]  base = '0;
  logic         big_page = 1'b0;
  logic         busy, done, hit, mem_req;
  logic [63:0]  entry, mem_addr;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hashed_xlat_probe u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .base(base),
    .big_page(big_page), .busy(busy), .done(done), .hit(hit), .entry(entry),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // Modes: 0 match, 1 locked, 2 one-bit mismatch, 3 context set, 4 zero tag
  task automatic probe(input logic [63:0] a, input logic [63:0] b, input logic big,
                       input int mode, input int lat, input logic [63:0] ent);
    logic [63:0] exp_addr, ctag, stag;
    logic        exp_hit;
    ctag = a >> 22;
    exp_addr = big ? b + (((a >> 22) & 64'd4095) << 4)
                   : b + (((a >> 13) & 64'd2047) << 4);
    case (mode)
      0: stag = ctag;
      1: stag = ctag | (64'd1 << 47);
      2: stag = ctag ^ 64'd1;
      3: stag = ctag | (64'd5 << 48);
      default: stag = 64'd0;
    endcase
    exp_hit = (mode == 0) && (stag != 0);
    @(negedge clk);
    va = a; base = b; big_page = big; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    va = ~a;
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    check("R2 req after start", {63'd0, mem_req}, 64'd1);
    check(big ? "R4 large slot addr" : "R3 small slot addr", mem_addr, exp_addr);
    for (int k = 0; k < lat; k++) begin
      if (k == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R5 req held", {63'd0, mem_req}, 64'd1);
      check("R2 R5 addr held", mem_addr, exp_addr);
    end
    mem_ack = 1'b1;
    mem_rdata = {ent, stag};
    @(negedge clk);
    mem_ack = 1'b0;
    mem_rdata = '1;
    check("R10 done pulse", {63'd0, done}, 64'd1);
    check("R10 idle at done", {62'd0, busy, mem_req}, 64'd0);
    case (mode)
      1: check("R7 lock forces miss", {63'd0, hit}, 64'd0);
      2, 3: check("R9 mismatch miss", {63'd0, hit}, 64'd0);
      4: check("R8 zero tag miss", {63'd0, hit}, 64'd0);
      default: check("R6 tag match hit", {63'd0, hit}, {63'd0, exp_hit});
    endcase
    if (exp_hit) check("R6 entry on hit", entry, ent);
    @(negedge clk);
    check("R10 done single", {62'd0, done, hit}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {60'd0, busy, done, hit, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {60'd0, busy, done, hit, mem_req}, 64'd0);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {32'(i) * 32'h9E3779B9, 32'(i) * 32'h7F4A7C15};
      b = 64'h0000_0040_0000_0000 + 64'(i) * 64'h1_0000;
      probe(a, b, i[0], i % 4, i % 4, {32'hE0E0_0000, 32'(i)});
    end
    probe(64'h0000_0000_0012_3000, 64'h1000_0000, 1'b0, 4, 1, 64'hAB);
    probe(64'h0000_0000_0034_5000, 64'h2000_0000, 1'b1, 4, 0, 64'hCD);
    probe(64'h0000_0000_0000_0000, 64'h3000_0000, 1'b1, 0, 2, 64'hEF);
    probe(64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000, 1'b0, 0, 1, 64'h12);
    probe(64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000, 1'b1, 1, 3, 64'h34);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule